// File: doc/BRIEF.md
# Serial Real-Time-Clock Command Port

This block is the slave side of a bit-serial link to a real-time-clock chip. A host toggles a serial clock and a data line, and frames a transaction with an active-low select. Each frame has sixteen bits. The first eight bits carry a command byte, most significant bit first. The last eight bits either carry a data byte from the host or return a byte to it.

Behind the link sit four things:
- a small battery RAM;
- a window onto BCD calendar and time values, which a separate timekeeper supplies on input ports;
- a status register and a control register;
- a power-fail interrupt.

A power-fail input raises the interrupt and two status flags. The host clears both by writing the control command with its clear bit set.

All three host-side inputs (select, serial clock, data) are asynchronous. They are resynchronized into the system clock domain, and each falling edge of the serial clock is found by comparing two consecutive synchronized samples.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset, `sdata_out` and `pwr_irq` are 0, and both the status register (read code 0x30) and the control register (read code 0x31) read back 0x00.
- R2: `sel_n`, `sclk` and `sdata_in` pass through a two-stage synchronizer. The frame state changes only on a synchronized high-to-low transition of `sclk`. The first eight such edges shift `sdata_in` into the command byte, most significant bit first.
- R3: A frame with command 0x80+a (a = 0..31) commits its data byte into RAM word a at the sixteenth falling edge. A later frame with read command a (0x00..0x1F) returns that byte.
- R4: Read codes in 0x20..0x2F return time values: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month, 0x26 year. Every other code in that range returns 0x00.
- R5: Read code 0x30 returns the status byte, whose only non-zero bits are the two power-fail flags at bits 3 and 4 (mask 0x18). Read code 0x31 returns the control byte.
- R6: A read command latches its return byte at the eighth falling edge. At each of falling edges 9 to 16, `sdata_out` takes the next bit of that byte, most significant bit first. Read codes with no mapped meaning return 0x00.
- R7: Command 0xB1 stores its data byte in the control register. If bit 2 of that byte is 1, the same commit clears both status flags and drops `pwr_irq`. If bit 2 is 0, the flags and the interrupt are left unchanged.
- R8: While `pwr_fail` is high, both status flags and `pwr_irq` are 1 on the next clock. They stay set after `pwr_fail` falls, until a clear by R7.
- R9: If a clear by R7 commits in a cycle where `pwr_fail` is high, the set wins: the flags and `pwr_irq` stay 1.
- R10: While the synchronized select is high, the phase, the command and data shift registers, and `sdata_out` are held at zero. A frame cut short by deselection changes no storage.
- R11: After the sixteenth falling edge, further falling edges are ignored until the next deselection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host; actions on its falling edge |
| sdata_in | input | 1 | Serial data from the host |
| sdata_out | output | 1 | Serial read data to the host |
| pwr_fail | input | 1 | Power-fail indication, synchronous to `clk` |
| bcd_sec | input | 8 | Current seconds, BCD |
| bcd_min | input | 8 | Current minutes, BCD |
| bcd_hour | input | 8 | Current hours, BCD |
| bcd_mday | input | 8 | Current day of month, BCD |
| bcd_month | input | 8 | Current month (1-based), BCD |
| bcd_year | input | 8 | Current year within the century, BCD |
| pwr_irq | output | 1 | Power-fail interrupt, sticky until cleared |

## Verification
Two functions can land in the same cycle: the power-fail set of the status flags, and the flag clear carried by a control write with bit 2 set. The bench provokes the collision by holding `pwr_fail` high through an entire 0xB1 frame whose data byte has bit 2 set. It then judges the outcome at the ports: `pwr_irq` must still be high, and a later status read must return 0x18. A second clear frame, sent after `pwr_fail` has fallen, must then succeed. That second frame shows the first clear was overridden, not lost to a decode fault.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;
   localparam int BYTE_W     = 8;
   localparam int FRAME_BITS = 2 * BYTE_W;

   typedef logic [BYTE_W-1:0] byte_t;

   localparam byte_t CODE_STATUS  = 8'h30;
   localparam byte_t CODE_CONTROL = 8'h31;
   localparam byte_t CODE_CTRL_WR = 8'hB1;
   localparam int    CLEAR_BIT    = 2;

   // Commands that carry a data byte from the host
   function automatic logic cmd_is_write(byte_t c);
      return (c[7:5] == 3'b100) || (c == CODE_CTRL_WR);
   endfunction
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[s] <= RST_VAL;
         else if (s == 0) stage_q[s] <= d;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rtc_frame.sv
module rtc_frame
   import rtc_serial_pkg::*;
#(
   parameter int PH_W = $clog2(FRAME_BITS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            fall,
   input  logic            din,
   input  byte_t           rd_byte,
   output byte_t           cmd_next,
   output logic            wr_commit,
   output byte_t           wr_cmd,
   output byte_t           wr_value,
   output logic            dout,
   output logic [PH_W-1:0] phase
);
   localparam logic [PH_W-1:0] PH_CMD_LAST  = PH_W'(BYTE_W - 1);
   localparam logic [PH_W-1:0] PH_DATA_LAST = PH_W'(FRAME_BITS - 1);
   localparam logic [PH_W-1:0] PH_DONE      = PH_W'(FRAME_BITS);

   byte_t cmd_q, value_q, ret_q;
   logic  in_cmd, in_data, step, rd_load;
   logic [2:0] bit_sel;

   assign cmd_next  = {cmd_q[BYTE_W-2:0], din};
   assign wr_value  = {value_q[BYTE_W-2:0], din};
   assign wr_cmd    = cmd_q;
   assign in_cmd    = phase <= PH_CMD_LAST;
   assign in_data   = !in_cmd && (phase <= PH_DATA_LAST);
   assign step      = active && fall && (phase != PH_DONE);
   assign rd_load   = step && (phase == PH_CMD_LAST) && !cmd_is_write(cmd_next);
   assign wr_commit = step && (phase == PH_DATA_LAST) && cmd_is_write(cmd_q);
   assign bit_sel   = ~phase[2:0];   // 7 - (phase - 8)

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0; cmd_q <= '0; value_q <= '0; ret_q <= '0; dout <= 1'b0;
      end else if (!active) begin
         phase <= '0; cmd_q <= '0; value_q <= '0; ret_q <= '0; dout <= 1'b0;
      end else if (step) begin
         phase <= phase + 1'b1;
         if (in_cmd)  cmd_q <= cmd_next;
         if (rd_load) ret_q <= rd_byte;
         if (in_data) begin
            if (cmd_is_write(cmd_q)) value_q <= wr_value;
            else                     dout    <= ret_q[bit_sel];
         end
      end
   end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_serial_pkg::*;
#(
   parameter int RAM_WORDS = 32,
   parameter bit RAM_RESET = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  byte_t lookup_cmd,
   input  logic  wr_commit,
   input  byte_t wr_cmd,
   input  byte_t wr_value,
   input  logic  pwr_fail,
   input  byte_t bcd_sec,
   input  byte_t bcd_min,
   input  byte_t bcd_hour,
   input  byte_t bcd_mday,
   input  byte_t bcd_month,
   input  byte_t bcd_year,
   output byte_t rd_byte,
   output logic [1:0] flags,
   output logic  pwr_irq
);
   localparam int         AW      = $clog2(RAM_WORDS);
   localparam logic [5:0] RAM_LIM = 6'(RAM_WORDS);

   if (RAM_WORDS < 2 || RAM_WORDS > 32 || (1 << AW) != RAM_WORDS) begin : g_bad_ram
      $error("RAM_WORDS must be a power of two from 2 to 32");
   end

   byte_t ram [RAM_WORDS];
   byte_t control_q, status_b;
   logic  ram_we, ctrl_we, clr_req;

   assign ram_we  = wr_commit && (wr_cmd[7:5] == 3'b100) && ({1'b0, wr_cmd[4:0]} < RAM_LIM);
   assign ctrl_we = wr_commit && (wr_cmd == CODE_CTRL_WR);
   assign clr_req = ctrl_we && wr_value[CLEAR_BIT];

   if (RAM_RESET) begin : g_ram_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < RAM_WORDS; i++) ram[i] <= '0;
         end else if (ram_we) begin
            ram[wr_cmd[AW-1:0]] <= wr_value;
         end
      end
   end else begin : g_ram_keep
      always_ff @(posedge clk) begin
         if (ram_we) ram[wr_cmd[AW-1:0]] <= wr_value;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         control_q <= '0; flags <= '0; pwr_irq <= 1'b0;
      end else begin
         if (ctrl_we) control_q <= wr_value;
         if (pwr_fail) begin          // set wins over a same-cycle clear
            flags <= 2'b11; pwr_irq <= 1'b1;
         end else if (clr_req) begin
            flags <= 2'b00; pwr_irq <= 1'b0;
         end
      end
   end

   assign status_b = {3'b000, flags, 3'b000};

   always_comb begin
      rd_byte = '0;
      if (lookup_cmd[7:5] == 3'b000) begin
         if ({1'b0, lookup_cmd[4:0]} < RAM_LIM) rd_byte = ram[lookup_cmd[AW-1:0]];
      end else if (lookup_cmd[7:4] == 4'h2) begin
         case (lookup_cmd[3:0])
            4'h0:    rd_byte = bcd_sec;
            4'h1:    rd_byte = bcd_min;
            4'h2:    rd_byte = bcd_hour;
            4'h4:    rd_byte = bcd_mday;
            4'h5:    rd_byte = bcd_month;
            4'h6:    rd_byte = bcd_year;
            default: rd_byte = '0;
         endcase
      end else if (lookup_cmd == CODE_STATUS) begin
         rd_byte = status_b;
      end else if (lookup_cmd == CODE_CONTROL) begin
         rd_byte = control_q;
      end
   end
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
   import rtc_serial_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RAM_WORDS   = 32,
   parameter bit RAM_RESET   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_n,
   input  logic       sclk,
   input  logic       sdata_in,
   output logic       sdata_out,
   input  logic       pwr_fail,
   input  logic [7:0] bcd_sec,
   input  logic [7:0] bcd_min,
   input  logic [7:0] bcd_hour,
   input  logic [7:0] bcd_mday,
   input  logic [7:0] bcd_month,
   input  logic [7:0] bcd_year,
   output logic       pwr_irq
);
   localparam int PH_W = $clog2(FRAME_BITS + 1);

   logic [2:0]      pins_s;
   logic            sclk_prev, fall, active;
   logic [PH_W-1:0] phase;
   logic [1:0]      flags;
   byte_t           cmd_next, rd_byte, wr_cmd, wr_value;
   logic            wr_commit;

   rtc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdata_in}), .q(pins_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= pins_s[1];
   end

   assign fall   = sclk_prev && !pins_s[1];
   assign active = !pins_s[2];

   rtc_frame #(.PH_W(PH_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .active(active), .fall(fall), .din(pins_s[0]),
      .rd_byte(rd_byte), .cmd_next(cmd_next), .wr_commit(wr_commit),
      .wr_cmd(wr_cmd), .wr_value(wr_value), .dout(sdata_out), .phase(phase));

   rtc_regs #(.RAM_WORDS(RAM_WORDS), .RAM_RESET(RAM_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .lookup_cmd(cmd_next), .wr_commit(wr_commit),
      .wr_cmd(wr_cmd), .wr_value(wr_value), .pwr_fail(pwr_fail),
      .bcd_sec(bcd_sec), .bcd_min(bcd_min), .bcd_hour(bcd_hour),
      .bcd_mday(bcd_mday), .bcd_month(bcd_month), .bcd_year(bcd_year),
      .rd_byte(rd_byte), .flags(flags), .pwr_irq(pwr_irq));
endmodule

// File: rtl/rtc_serial_port_chk.sv
module rtc_serial_port_chk #(
   parameter int PH_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pwr_fail,
   input logic            pwr_irq,
   input logic            sdata_out,
   input logic            active,
   input logic            fall,
   input logic [PH_W-1:0] phase,
   input logic [1:0]      flags
);
   p_phase_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= PH_W'(16));

   p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !fall) |=> $stable(phase));

   p_fail_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (pwr_irq && flags == 2'b11));

   p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_irq) |-> !$past(pwr_fail));

   p_quiet_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!sdata_out && phase == '0));

   p_out_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !fall) |=> $stable(sdata_out));
endmodule

bind rtc_serial_port rtc_serial_port_chk #(.PH_W(PH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .pwr_irq(pwr_irq),
   .sdata_out(sdata_out), .active(active), .fall(fall), .phase(phase),
   .flags(flags));

// File: tb/rtc_serial_port_bench.sv
module rtc_serial_port_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0, sel_n = 1'b1, sclk = 1'b0, sdata_in = 1'b0, pwr_fail = 1'b0;
   logic sdata_out, pwr_irq;
   logic [7:0] bcd_sec = 8'h59, bcd_min = 8'h42, bcd_hour = 8'h23;
   logic [7:0] bcd_mday = 8'h31, bcd_month = 8'h12, bcd_year = 8'h24;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rtc_serial_port u_rtc_serial_port (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata_in(sdata_in),
      .sdata_out(sdata_out), .pwr_fail(pwr_fail), .bcd_sec(bcd_sec),
      .bcd_min(bcd_min), .bcd_hour(bcd_hour), .bcd_mday(bcd_mday),
      .bcd_month(bcd_month), .bcd_year(bcd_year), .pwr_irq(pwr_irq));

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic b, output logic o);
      sdata_in = b; sclk = 1'b1; tick(8);
      sclk = 1'b0; tick(8);
      o = sdata_out;
   endtask

   // Sends nbits of a 32-bit stream MSB first, returns the last 8 sampled outputs
   task automatic run(logic [31:0] bits, int nbits, output logic [7:0] rd);
      logic o;
      rd = '0;
      sel_n = 1'b0; tick(4);
      for (int i = 0; i < nbits; i++) begin
         send_bit(bits[31-i], o);
         rd = {rd[6:0], o};
      end
      sel_n = 1'b1; tick(6);
   endtask

   task automatic xfer(logic [7:0] cmd, logic [7:0] wd, output logic [7:0] rd);
      run({cmd, wd, 16'h0}, 16, rd);
   endtask

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 5) ^ 8'hA6);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      tick(3); rst_n = 1'b1; tick(4);
      // R1 reset state
      check("R1 sdata_out", {7'b0, sdata_out}, 8'h00);
      check("R1 pwr_irq", {7'b0, pwr_irq}, 8'h00);
      xfer(8'h30, 8'h00, rd); check("R1 status", rd, 8'h00);
      xfer(8'h31, 8'h00, rd); check("R1 control", rd, 8'h00);

      // R3/R2 RAM sweep, MSB-first command and data
      for (int a = 0; a < 32; a++) xfer(8'(8'h80 + a), pat(a), rd);
      for (int a = 0; a < 32; a++) begin
         xfer(8'(a), 8'h00, rd);
         check("R3 R2 ram read", rd, pat(a));
      end

      // R4 time window sweep
      for (int c = 8'h20; c <= 8'h2F; c++) begin
         logic [7:0] exp;
         case (c)
            8'h20: exp = bcd_sec;   8'h21: exp = bcd_min;  8'h22: exp = bcd_hour;
            8'h24: exp = bcd_mday;  8'h25: exp = bcd_month; 8'h26: exp = bcd_year;
            default: exp = 8'h00;
         endcase
         xfer(8'(c), 8'h00, rd);
         check("R4 time read", rd, exp);
      end

      // R6 unmapped reads
      xfer(8'h40, 8'h00, rd); check("R6 unmapped 40", rd, 8'h00);
      xfer(8'hA0, 8'h00, rd); check("R6 unmapped A0", rd, 8'h00);
      xfer(8'hFF, 8'h00, rd); check("R6 unmapped FF", rd, 8'h00);

      // R5/R7 control write without clear bit
      xfer(8'hB1, 8'h5A, rd);
      xfer(8'h31, 8'h00, rd); check("R5 R7 control read", rd, 8'h5A);

      // R8 power fail sets flags and sticky irq
      pwr_fail = 1'b1; tick(1); pwr_fail = 1'b0; tick(2);
      check("R8 irq set", {7'b0, pwr_irq}, 8'h01);
      xfer(8'h30, 8'h00, rd); check("R8 R5 status flags", rd, 8'h18);
      xfer(8'hB1, 8'hFB, rd);
      check("R7 no clear without bit2", {7'b0, pwr_irq}, 8'h01);
      xfer(8'h30, 8'h00, rd); check("R7 flags kept", rd, 8'h18);

      // R9 collision: clear during held power fail
      pwr_fail = 1'b1;
      xfer(8'hB1, 8'h04, rd);
      pwr_fail = 1'b0; tick(2);
      check("R9 irq survives", {7'b0, pwr_irq}, 8'h01);
      xfer(8'h30, 8'h00, rd); check("R9 flags survive", rd, 8'h18);

      // R7 clear takes effect
      xfer(8'hB1, 8'h04, rd);
      check("R7 irq cleared", {7'b0, pwr_irq}, 8'h00);
      xfer(8'h30, 8'h00, rd); check("R7 flags cleared", rd, 8'h00);
      xfer(8'h31, 8'h00, rd); check("R7 control value", rd, 8'h04);

      // R11 extra edges after a complete frame ignored
      run({8'h80, 8'h11, 8'h80, 8'h77}, 32, rd);
      xfer(8'h00, 8'h00, rd); check("R11 extra edges ignored", rd, 8'h11);

      // R10 aborted write frame changes nothing
      run({8'h81, 8'h3C, 16'h0}, 12, rd);
      xfer(8'h01, 8'h00, rd); check("R10 partial write", rd, pat(1));
      run({8'h05, 24'h0}, 4, rd);
      xfer(8'h02, 8'h00, rd); check("R10 frame after abort", rd, pat(2));
      check("R10 out low deselected", {7'b0, sdata_out}, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule